// File: doc/BRIEF.md
# Streaming CRC-32C Update Engine

This block computes the Castagnoli CRC-32 over a stream of message beats, one beat per clock. Each beat is either a single byte or an eight-byte little-endian word, chosen per beat by a width select. A producer usually sends an unaligned head and a short tail as single bytes and the aligned middle as words. The result is the same however the message is split between the two beat kinds.

A message begins with a start strobe that loads the running remainder with the inverted seed. The seed is 0 for a fresh message, or an earlier result when a message is continued. On the beat marked last, the inverted final remainder is registered onto the result output, and a done flag is raised for that one cycle.

The input is a valid/ready stream. Ready is always high, so the block never applies back-pressure and every cycle with valid high consumes one beat. Start, seed, done and the result are plain pins.

Top module: `crc32c_stream`

## Requirements
- R1: While reset is low and on the first cycle after it, crc_o reads 0 and done_o reads 0.
- R2: A byte beat (wide_i=0) XORs data_i[7:0] into the low byte of the remainder. It then applies eight right-shift steps, each XORing 0x82F63B78 when the bit shifted out is 1.
- R3: A word beat (wide_i=1) takes byte k of the message from data_i[8k+7:8k], k=0 being first. Its result equals eight byte beats of those bytes in order k=0..7.
- R4: start_i loads the remainder with the bitwise inverse of seed_i. When start_i and in_valid_i are high together, the beat is applied to that freshly loaded value.
- R5: While in_valid_i is low and start_i is low, the remainder holds. data_i, wide_i and last_i have no effect.
- R6: The clock edge that accepts a beat with last_i=1 sets crc_o to the bitwise inverse of the updated remainder and sets done_o to 1.
- R7: done_o is 1 only in the cycle after a last beat. crc_o keeps its value whenever done_o is 0.
- R8: Starting a message with seed_i set to a previous result gives the CRC of the two messages concatenated.
- R9: in_ready_o is 1 whenever reset is released, so every valid beat is consumed in its cycle.
- R10: The nine ASCII bytes "123456789" with seed 0 give 0xE3069283. Thirty-two zero bytes give 0x8A9136AA, thirty-two 0xFF bytes give 0x62A8AB43, and bytes 0x00..0x1F give 0x46DD794E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a message: load the remainder from the inverted seed |
| seed_i | input | 32 | Starting CRC, 0 for a fresh message |
| in_valid_i | input | 1 | Beat present on data_i |
| in_ready_o | output | 1 | Beat accepted (always 1 out of reset) |
| wide_i | input | 1 | 0: byte beat, 1: eight-byte word beat |
| data_i | input | 64 | Beat data, byte 0 in bits 7:0 |
| last_i | input | 1 | Final beat of the message |
| crc_o | output | 32 | Final CRC of the last message |
| done_o | output | 1 | One-cycle flag: crc_o was just updated |

## Verification
The hardest case to reach from the ports is a single message whose byte path and word path interleave at every possible alignment, with idle gaps carrying misleading data and last values. The stimulus sweeps every head length from 0 to 7 over message lengths up to 40 bytes. It inserts idle cycles with scrambled inputs between beats and compares against a bit-serial reference. Every single-byte message value and seed chaining across split points are covered as well.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] POLY_REFL = 32'h82F63B78;
endpackage

// File: rtl/crc32c_xor_net.sv
// Unrolled bit-serial update: DATA_W right-shift steps, data consumed LSB first.
module crc32c_xor_net #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned DATA_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'h82F63B78
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [CRC_W-1:0] stage [0:DATA_W];

  assign stage[0] = crc_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb = stage[i][0] ^ data_i[i];
    assign stage[i+1] = (stage[i] >> 1) ^ (fb ? POLY : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc32c_out_stage.sv
// Result register and one-cycle completion flag.
module crc32c_out_stage #(
  parameter int unsigned CRC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [CRC_W-1:0] rem_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      crc_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= fire_i;
      if (fire_i) crc_o <= ~rem_i;
    end
  end
endmodule

// File: rtl/crc32c_stream.sv
module crc32c_stream #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [crc32c_pkg::CRC_W-1:0]    seed_i,
  input  logic                            in_valid_i,
  output logic                            in_ready_o,
  input  logic                            wide_i,
  input  logic [BYTE_W*LANES-1:0]         data_i,
  input  logic                            last_i,
  output logic [crc32c_pkg::CRC_W-1:0]    crc_o,
  output logic                            done_o
);
  import crc32c_pkg::*;

  localparam int unsigned WORD_W = BYTE_W * LANES;

  logic [CRC_W-1:0] state_q;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] byte_res;
  logic [CRC_W-1:0] word_res;
  logic [CRC_W-1:0] beat_res;
  logic             fire;

  assign in_ready_o = rst_ni;
  assign base       = start_i ? ~seed_i : state_q;

  crc32c_xor_net #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(POLY_REFL)) u_byte_net (
    .crc_i  (base),
    .data_i (data_i[BYTE_W-1:0]),
    .crc_o  (byte_res)
  );

  crc32c_xor_net #(.CRC_W(CRC_W), .DATA_W(WORD_W), .POLY(POLY_REFL)) u_word_net (
    .crc_i  (base),
    .data_i (data_i),
    .crc_o  (word_res)
  );

  assign beat_res = wide_i ? word_res : byte_res;
  assign fire     = in_valid_i & last_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q <= '1;
    end else if (in_valid_i) begin
      state_q <= beat_res;
    end else if (start_i) begin
      state_q <= ~seed_i;
    end
  end

  crc32c_out_stage #(.CRC_W(CRC_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .rem_i  (beat_res),
    .crc_o  (crc_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/crc32c_stream_chk.sv
module crc32c_stream_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [31:0] seed_i,
  input logic        in_valid_i,
  input logic        last_i,
  input logic [31:0] crc_o,
  input logic        done_o,
  input logic [31:0] state_q
);
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && last_i) |=> done_o); // R6

  AST_DONE_ONLY_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && last_i) |=> !done_o); // R7

  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && last_i) |=> $stable(crc_o)); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !start_i) |=> $stable(state_q)); // R5

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !in_valid_i) |=> (state_q == ~$past(seed_i))); // R4
endmodule

bind crc32c_stream crc32c_stream_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .seed_i     (seed_i),
  .in_valid_i (in_valid_i),
  .last_i     (last_i),
  .crc_o      (crc_o),
  .done_o     (done_o),
  .state_q    (state_q)
);

// File: tb/crc32c_stream_test.sv
`timescale 1ns/1ps
module crc32c_stream_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] seed = '0;
  logic        valid = 1'b0;
  logic        ready;
  logic        wide = 1'b0;
  logic [63:0] data = '0;
  logic        last = 1'b0;
  logic [31:0] crc;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] msg [0:63];

  always #4 clk = ~clk;

  crc32c_stream uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seed_i(seed),
    .in_valid_i(valid), .in_ready_o(ready), .wide_i(wide), .data_i(data),
    .last_i(last), .crc_o(crc), .done_o(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] s, input int from, input int n);
    logic [31:0] r = ~s;
    for (int i = 0; i < n; i++) begin
      r = r ^ {24'd0, msg[from+i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'h82F63B78) : (r >> 1);
    end
    return ~r;
  endfunction

  task automatic idle_gap();
    valid = 1'b0; start = 1'b0; last = 1'b1; wide = ~wide;
    data = {$urandom, $urandom};
    @(negedge clk);
    last = 1'b0;
  endtask

  task automatic beat(input logic st, input logic w, input logic [63:0] d, input logic l, input bit gap);
    start = st; valid = 1'b1; wide = w; data = d; last = l;
    @(posedge clk); @(negedge clk);
    valid = 1'b0; start = 1'b0; last = 1'b0;
    if (gap && !l) idle_gap();
  endtask

  // Sends msg[from +: n] with `head` leading byte beats, words in the middle, bytes at the tail.
  task automatic send_msg(input int from, input int n, input int head, input logic [31:0] s,
                          input bit sep_start, input bit gaps, input string req,
                          output logic [31:0] result);
    int idx = from;
    int rem = n;
    int h = head;
    logic first = 1'b1;
    logic [63:0] w;
    seed = s;
    if (sep_start) begin
      start = 1'b1; @(posedge clk); @(negedge clk); start = 1'b0; first = 1'b0;
      if (gaps) idle_gap();
    end
    while (rem > 0) begin
      if (h > 0 || rem < 8) begin
        beat(first, 1'b0, {$urandom, $urandom[23:0], msg[idx]}, rem == 1, gaps);
        idx++; rem--; if (h > 0) h--;
      end else begin
        for (int k = 0; k < 8; k++) w[8*k +: 8] = msg[idx+k];
        beat(first, 1'b1, w, rem == 8, gaps);
        idx += 8; rem -= 8;
      end
      first = 1'b0;
    end
    check({req, " done"}, {31'd0, done}, 32'd1);
    check(req, crc, ref_crc(s, from, n));
    result = crc;
    @(negedge clk);
    check("R7 done drops", {31'd0, done}, 32'd0);
    check("R7 crc holds", crc, result);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, ra;
    string s9;
    repeat (3) @(negedge clk);
    check("R1 crc reset", crc, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 crc after reset", crc, 32'd0);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    check("R9 ready", {31'd0, ready}, 32'd1);

    // R10 known vectors
    s9 = "123456789";
    for (int i = 0; i < 9; i++) msg[i] = s9[i];
    send_msg(0, 9, 1, 32'd0, 0, 0, "R10 123456789", r);
    check("R10 check value", r, 32'hE3069283);
    for (int i = 0; i < 32; i++) msg[i] = 8'h00;
    send_msg(0, 32, 0, 32'd0, 0, 0, "R10 zeros", r);
    check("R10 zeros value", r, 32'h8A9136AA);
    for (int i = 0; i < 32; i++) msg[i] = 8'hFF;
    send_msg(0, 32, 3, 32'd0, 1, 1, "R10 ones", r);
    check("R10 ones value", r, 32'h62A8AB43);
    for (int i = 0; i < 32; i++) msg[i] = i[7:0];
    send_msg(0, 32, 0, 32'd0, 0, 1, "R10 ramp", r);
    check("R10 ramp value", r, 32'h46DD794E);

    // R2: every single-byte message through the byte path
    for (int v = 0; v < 256; v++) begin
      msg[0] = v[7:0];
      send_msg(0, 1, 1, 32'(v * 32'h01010101), 0, 0, "R2 byte sweep", r);
    end

    // R3 R4 R5: all head alignments, many lengths, separate or fused start, idle gaps
    for (int n = 1; n <= 40; n++) begin
      for (int h = 0; h < 8; h++) begin
        for (int i = 0; i < 64; i++) msg[i] = 8'($urandom);
        send_msg(0, n, h, $urandom, (n + h) % 2 == 1, (h % 3) == 0,
                 (h == 0 && n >= 8) ? "R3 word path" : ((n + h) % 2 == 1 ? "R4 separate start" : "R5 gaps mixed"), r);
      end
    end

    // R8: chaining across split points
    for (int sp = 1; sp < 24; sp += 3) begin
      for (int i = 0; i < 24; i++) msg[i] = 8'($urandom);
      send_msg(0, sp, sp % 8, 32'd0, 0, 1, "R8 first part", ra);
      send_msg(sp, 24 - sp, 0, ra, 1, 0, "R8 continued", r);
      check("R8 chained whole", r, ref_crc(32'd0, 0, 24));
    end

    check("R9 ready at end", {31'd0, ready}, 32'd1);
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule